// File: doc/BRIEF.md
# Exception Entry and Vector Logic

This block sits at the point where a processor pipeline gives up on an instruction. When a general exception request or a debug breakpoint arrives, it records where the fault happened and why in a small set of control registers. It then drives a redirect PC and a one-cycle valid strobe that tells the fetch logic where the handler starts. The registers are a cause register, a status register, an exception PC, a debug-control register and a debug exception PC. Every taken request also drops the load-linked reservation flag, so any atomic read-modify-write sequence that is in progress fails its store-conditional.

Two entry paths exist:

- **General path.** It respects the status exception-level flag. While that flag is set, nested faults refresh only the cause code and keep the first saved PC. A fault in a branch delay slot backs the saved PC off to the branch.
- **Debug path.** It is taken only outside debug mode. It has its own saved PC, its own delay-slot flag and a fixed vector, and it wins over a general request that arrives in the same cycle.

A parameter selects an alternate status and vector scheme. In it, the low status bits form a two-deep history stack, and the saved PC is written on every exception.

Two simple inputs complete the interface. A return-clear input clears the exception-level and debug-mode flags. A boot-clear input drops the boot-vector select flag.

Top module: `trap_entry`

## Requirements
- R1: After reset the redirect PC is 0xBFC00000 and valid is 0. Status holds only the error-level bit (bit 2) and the boot-vector bit BEV (bit 22) set; the SR, TS and RP bits (20, 21, 27) and all other status bits are 0. Cause, saved PC, debug control, debug saved PC and the reservation flag are 0.
- R2: A taken general exception writes its 5-bit code into cause bits 6:2. In the default mode, cause bits 30:7 and 1:0 become 0.
- R3: In the default mode, a general exception taken with the exception-level bit EXL (status bit 1) clear sets EXL. It writes the saved PC with the instruction address and clears cause bit 31 (BD). If the delay-slot input is high, it writes address minus 4 instead and sets BD.
- R4: In the default mode, a general exception taken with EXL already set leaves the saved PC and BD unchanged, updates the code and keeps EXL set.
- R5: In the default mode, the general vector is 0xBFC00380 when BEV is 1 and 0x80000180 when BEV is 0. A pulse on the boot-clear input clears BEV.
- R6: A debug breakpoint taken while DM (debug bit 30) is clear does the following. It sets DM and DBp (debug bit 1). It writes the debug saved PC with the address and clears DBD (debug bit 31). If the delay-slot input is high, it writes address minus 4 instead and sets DBD. It redirects to 0xBFC00200.
- R7: A debug breakpoint while DM is set is ignored. No redirect happens, and the debug register and the debug saved PC keep their values.
- R8: A debug breakpoint that is taken has priority over a general request in the same cycle. Cause, saved PC and status keep their values.
- R9: The reservation-set input sets the reservation flag. Any taken request clears it, and the clear wins when both happen in one cycle.
- R10: Valid is high for exactly the one cycle after the edge that takes a request. All register updates and the new redirect PC appear at that same edge, and the PC then holds its value.
- R11: The return-clear input clears EXL and DM. A request taken in the same cycle still sets its flag, and it uses the flag values from before that edge.
- R12: In the alternate mode, an exception does the following:
  - It replaces status bits 5:2 with the old bits 3:0, clears bits 1:0, and does not set EXL.
  - It always writes the saved PC, backed off when the delay-slot input is high.
  - It sets BD on a delay slot and otherwise keeps BD.
  - It vectors to 0xBFC00180 when BEV is 1 and to 0x80000180 when BEV is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | General exception request |
| exc_code_i | input | 5 | Exception code |
| inst_addr_i | input | 32 | Address of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction sits in a branch delay slot |
| dbg_brk_i | input | 1 | Debug breakpoint request |
| ret_clr_i | input | 1 | Clear EXL and DM (handler return) |
| bev_clr_i | input | 1 | Clear the boot-vector select bit |
| ll_set_i | input | 1 | Set the load-linked reservation flag |
| redirect_pc_o | output | 32 | Handler address |
| redirect_vld_o | output | 1 | One-cycle redirect strobe |
| cause_o | output | 32 | Cause register |
| status_o | output | 32 | Status register |
| epc_o | output | 32 | Exception saved PC |
| dbg_ctl_o | output | 32 | Debug control register |
| depc_o | output | 32 | Debug saved PC |
| ll_bit_o | output | 1 | Load-linked reservation flag |

## Verification
Every result is one register stage from its cause. Inputs sampled at a rising edge show up on the redirect PC, the strobe, the five registers and the reservation flag right after that edge. The strobe must be low again one edge later. The bench drives stimulus on the falling edge, holds it across one rising edge, and reads all outputs at the next falling edge. It then waits one more falling edge to confirm that the strobe has dropped and the PC holds. Ignored requests and same-cycle conflicts are judged from the register values read at that same falling edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // status bits
  localparam int unsigned ST_EXL = 1;
  localparam int unsigned ST_ERL = 2;
  localparam int unsigned ST_SR  = 20;
  localparam int unsigned ST_TS  = 21;
  localparam int unsigned ST_BEV = 22;
  localparam int unsigned ST_RP  = 27;
  // cause bits
  localparam int unsigned CA_CODE_LO = 2;
  localparam int unsigned CA_BD      = 31;
  // debug control bits
  localparam int unsigned DB_DBP = 1;
  localparam int unsigned DB_DM  = 30;
  localparam int unsigned DB_DBD = 31;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXC  = 2'd1,
    ACT_DBG  = 2'd2
  } trap_act_e;
endpackage

// File: rtl/trap_status_reg.sv
module trap_status_reg #(
  parameter int unsigned XLEN     = 32,
  parameter bit          ALT_MODE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_exc_i,
  input  logic            ret_clr_i,
  input  logic            bev_clr_i,
  output logic [XLEN-1:0] status_o
);
  import trap_pkg::*;

  localparam logic [XLEN-1:0] RST_VAL = (XLEN'(1) << ST_ERL) | (XLEN'(1) << ST_BEV);

  logic [XLEN-1:0] q, base, nxt;

  generate
    if (ALT_MODE) begin : g_alt
      // two-deep mode/enable history stack in bits 5:0
      always_comb begin
        base = q;
        if (take_exc_i) base = {q[XLEN-1:6], q[3:0], 2'b00};
      end
    end else begin : g_std
      always_comb base = q;
    end
  endgenerate

  always_comb begin
    nxt = base;
    if (bev_clr_i) nxt[ST_BEV] = 1'b0;
    if (ret_clr_i) nxt[ST_EXL] = 1'b0;
    if (!ALT_MODE && take_exc_i) nxt[ST_EXL] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= nxt;
  end

  assign status_o = q;
endmodule

// File: rtl/trap_cause_epc.sv
module trap_cause_epc #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CODE_W   = 5,
  parameter bit          ALT_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_exc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic              delay_i,
  input  logic              exl_i,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  import trap_pkg::*;

  localparam int unsigned CODE_HI = CA_CODE_LO + CODE_W - 1;

  logic [XLEN-1:0] cause_q, cause_n, epc_q, epc_n, back_addr;

  assign back_addr = addr_i - XLEN'(4);

  generate
    if (ALT_MODE) begin : g_alt
      always_comb begin
        cause_n = cause_q;
        epc_n   = epc_q;
        if (take_exc_i) begin
          cause_n[CODE_HI:CA_CODE_LO] = code_i;
          cause_n[1:0]                = 2'b00;
          if (delay_i) cause_n[CA_BD] = 1'b1;
          epc_n = delay_i ? back_addr : addr_i;
        end
      end
    end else begin : g_std
      always_comb begin
        cause_n = cause_q;
        epc_n   = epc_q;
        if (take_exc_i) begin
          cause_n                     = '0;
          cause_n[CODE_HI:CA_CODE_LO] = code_i;
          if (exl_i) begin
            // nested: code only
            cause_n[CA_BD] = cause_q[CA_BD];
          end else begin
            cause_n[CA_BD] = delay_i;
            epc_n          = delay_i ? back_addr : addr_i;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_n;
      epc_q   <= epc_n;
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;
endmodule

// File: rtl/trap_debug_reg.sv
module trap_debug_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_dbg_i,
  input  logic            ret_clr_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic            delay_i,
  output logic [XLEN-1:0] dbg_ctl_o,
  output logic [XLEN-1:0] depc_o
);
  import trap_pkg::*;

  logic [XLEN-1:0] ctl_q, ctl_n, depc_q, depc_n;

  always_comb begin
    ctl_n  = ctl_q;
    depc_n = depc_q;
    if (ret_clr_i) ctl_n[DB_DM] = 1'b0;
    if (take_dbg_i) begin
      ctl_n[DB_DBD] = delay_i;
      ctl_n[DB_DM]  = 1'b1;
      ctl_n[DB_DBP] = 1'b1;
      depc_n        = delay_i ? addr_i - XLEN'(4) : addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      depc_q <= '0;
    end else begin
      ctl_q  <= ctl_n;
      depc_q <= depc_n;
    end
  end

  assign dbg_ctl_o = ctl_q;
  assign depc_o    = depc_q;
endmodule

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int unsigned    XLEN      = 32,
  parameter int unsigned    CODE_W    = 5,
  parameter bit             ALT_MODE  = 1'b0,
  parameter logic [31:0]    BOOT_BASE = 32'hBFC0_0000,
  parameter logic [31:0]    RUN_BASE  = 32'h8000_0000,
  parameter logic [31:0]    DBG_VEC   = 32'hBFC0_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   inst_addr_i,
  input  logic              in_delay_i,
  input  logic              dbg_brk_i,
  input  logic              ret_clr_i,
  input  logic              bev_clr_i,
  input  logic              ll_set_i,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              redirect_vld_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   dbg_ctl_o,
  output logic [XLEN-1:0]   depc_o,
  output logic              ll_bit_o
);
  import trap_pkg::*;

  localparam logic [XLEN-1:0] OFS_GEN  = XLEN'(32'h180);
  localparam logic [XLEN-1:0] OFS_BOOT = ALT_MODE ? XLEN'(32'h180) : XLEN'(32'h380);
  localparam logic [XLEN-1:0] VEC_BOOT = XLEN'(BOOT_BASE) + OFS_BOOT;
  localparam logic [XLEN-1:0] VEC_RUN  = XLEN'(RUN_BASE) + OFS_GEN;

  trap_act_e       act;
  logic            take_exc, take_dbg, take_any;
  logic [XLEN-1:0] gen_vec, pc_q;
  logic            vld_q, ll_q;

  // debug wins when not already in debug mode
  always_comb begin
    if (dbg_brk_i && !dbg_ctl_o[DB_DM]) act = ACT_DBG;
    else if (exc_req_i)                 act = ACT_EXC;
    else                                act = ACT_NONE;
  end

  assign take_dbg = (act == ACT_DBG);
  assign take_exc = (act == ACT_EXC);
  assign take_any = take_dbg | take_exc;
  assign gen_vec  = status_o[ST_BEV] ? VEC_BOOT : VEC_RUN;

  trap_status_reg #(.XLEN(XLEN), .ALT_MODE(ALT_MODE)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_exc_i (take_exc),
    .ret_clr_i  (ret_clr_i),
    .bev_clr_i  (bev_clr_i),
    .status_o   (status_o)
  );

  trap_cause_epc #(.XLEN(XLEN), .CODE_W(CODE_W), .ALT_MODE(ALT_MODE)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_exc_i (take_exc),
    .code_i     (exc_code_i),
    .addr_i     (inst_addr_i),
    .delay_i    (in_delay_i),
    .exl_i      (status_o[ST_EXL]),
    .cause_o    (cause_o),
    .epc_o      (epc_o)
  );

  trap_debug_reg #(.XLEN(XLEN)) u_debug (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_dbg_i (take_dbg),
    .ret_clr_i  (ret_clr_i),
    .addr_i     (inst_addr_i),
    .delay_i    (in_delay_i),
    .dbg_ctl_o  (dbg_ctl_o),
    .depc_o     (depc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= XLEN'(BOOT_BASE);
      vld_q <= 1'b0;
      ll_q  <= 1'b0;
    end else begin
      vld_q <= take_any;
      if (take_dbg)      pc_q <= XLEN'(DBG_VEC);
      else if (take_exc) pc_q <= gen_vec;
      if (take_any)      ll_q <= 1'b0;
      else if (ll_set_i) ll_q <= 1'b1;
    end
  end

  assign redirect_pc_o  = pc_q;
  assign redirect_vld_o = vld_q;
  assign ll_bit_o       = ll_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CODE_W   = 5,
  parameter bit          ALT_MODE = 1'b0,
  parameter logic [31:0] DBG_VEC  = 32'hBFC0_0200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_req_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              dbg_brk_i,
  input logic [XLEN-1:0]   redirect_pc_o,
  input logic              redirect_vld_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   epc_o,
  input logic [XLEN-1:0]   dbg_ctl_o,
  input logic              ll_bit_o
);
  logic dm, dbg_win;
  assign dm      = dbg_ctl_o[30];
  assign dbg_win = dbg_brk_i && !dm;

  // R10
  vld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_vld_o |-> $past(exc_req_i || dbg_brk_i));

  // R9
  ll_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_vld_o |-> !ll_bit_o);

  // R6
  dbg_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_win |=> (redirect_vld_o && redirect_pc_o == XLEN'(DBG_VEC) && dbg_ctl_o[30]));

  // R7
  dbg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_brk_i && dm && !exc_req_i) |=> !redirect_vld_o);

  // R2
  code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !dbg_win) |=> cause_o[CODE_W+1:2] == $past(exc_code_i));

  // R4
  nest_epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ALT_MODE && exc_req_i && !dbg_win && status_o[1]) |=> $stable(epc_o));

  // R8
  dbg_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_win && exc_req_i) |=> ($stable(cause_o) && $stable(epc_o)));
endmodule

bind trap_entry trap_entry_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .ALT_MODE(ALT_MODE), .DBG_VEC(DBG_VEC)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .exc_req_i      (exc_req_i),
  .exc_code_i     (exc_code_i),
  .dbg_brk_i      (dbg_brk_i),
  .redirect_pc_o  (redirect_pc_o),
  .redirect_vld_o (redirect_vld_o),
  .cause_o        (cause_o),
  .status_o       (status_o),
  .epc_o          (epc_o),
  .dbg_ctl_o      (dbg_ctl_o),
  .ll_bit_o       (ll_bit_o)
);

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // default-mode instance inputs
  logic        m_exc = 0, m_dly = 0, m_dbg = 0, m_ret = 0, m_bev = 0, m_ll = 0;
  logic [4:0]  m_code = '0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_pc, m_cause, m_status, m_epc, m_dctl, m_depc;
  logic        m_vld, m_llb;

  // alternate-mode instance inputs
  logic        a_exc = 0, a_dly = 0, a_bev = 0;
  logic [4:0]  a_code = '0;
  logic [31:0] a_addr = '0;
  logic [31:0] a_pc, a_cause, a_status, a_epc, a_dctl, a_depc;
  logic        a_vld, a_llb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  trap_entry u_trap_entry (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(m_exc), .exc_code_i(m_code),
    .inst_addr_i(m_addr), .in_delay_i(m_dly), .dbg_brk_i(m_dbg),
    .ret_clr_i(m_ret), .bev_clr_i(m_bev), .ll_set_i(m_ll),
    .redirect_pc_o(m_pc), .redirect_vld_o(m_vld), .cause_o(m_cause),
    .status_o(m_status), .epc_o(m_epc), .dbg_ctl_o(m_dctl),
    .depc_o(m_depc), .ll_bit_o(m_llb)
  );

  trap_entry #(.ALT_MODE(1'b1)) u_trap_entry_alt (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(a_exc), .exc_code_i(a_code),
    .inst_addr_i(a_addr), .in_delay_i(a_dly), .dbg_brk_i(1'b0),
    .ret_clr_i(1'b0), .bev_clr_i(a_bev), .ll_set_i(1'b0),
    .redirect_pc_o(a_pc), .redirect_vld_o(a_vld), .cause_o(a_cause),
    .status_o(a_status), .epc_o(a_epc), .dbg_ctl_o(a_dctl),
    .depc_o(a_depc), .ll_bit_o(a_llb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // hold driven inputs across one rising edge, release, sample at falling edge
  task automatic step();
    @(negedge clk);
    m_exc = 0; m_dly = 0; m_dbg = 0; m_ret = 0; m_bev = 0; m_ll = 0;
    a_exc = 0; a_dly = 0; a_bev = 0;
  endtask

  task automatic t_reset();
    chk("R1 pc", m_pc, 32'hBFC0_0000);
    chk("R1 vld", 32'(m_vld), 0);
    chk("R1 status", m_status, 32'h0040_0004);
    chk("R1 cause", m_cause, 0);
    chk("R1 epc", m_epc, 0);
    chk("R1 dbg", m_dctl, 0);
    chk("R1 depc", m_depc, 0);
    chk("R1 ll", 32'(m_llb), 0);
  endtask

  task automatic t_first_exc();
    m_ll = 1; step();
    chk("R9 ll set", 32'(m_llb), 1);
    m_exc = 1; m_code = 5'd5; m_addr = 32'h1000; m_ll = 1; step();
    chk("R10 vld", 32'(m_vld), 1);
    chk("R5 vec boot", m_pc, 32'hBFC0_0380);
    chk("R2 cause", m_cause, 32'h0000_0014);
    chk("R3 epc", m_epc, 32'h1000);
    chk("R3 status exl", m_status, 32'h0040_0006);
    chk("R9 ll clear wins", 32'(m_llb), 0);
    @(negedge clk);
    chk("R10 vld drop", 32'(m_vld), 0);
    chk("R10 pc hold", m_pc, 32'hBFC0_0380);
  endtask

  task automatic t_nested();
    m_exc = 1; m_code = 5'd9; m_addr = 32'h2000; m_dly = 1; step();
    chk("R4 cause", m_cause, 32'h0000_0024);
    chk("R4 epc", m_epc, 32'h1000);
    chk("R4 status", m_status, 32'h0040_0006);
  endtask

  task automatic t_ret_bev_delay();
    m_ret = 1; m_bev = 1; step();
    chk("R11 exl clr", m_status, 32'h0000_0004);
    chk("R5 no vld", 32'(m_vld), 0);
    m_exc = 1; m_code = 5'd3; m_addr = 32'h3000; m_dly = 1; step();
    chk("R3 epc back", m_epc, 32'h2FFC);
    chk("R3 cause bd", m_cause, 32'h8000_000C);
    chk("R5 vec run", m_pc, 32'h8000_0180);
    chk("R3 exl", m_status, 32'h0000_0006);
  endtask

  task automatic t_ret_race();
    m_ret = 1; m_exc = 1; m_code = 5'd1; m_addr = 32'h3100; step();
    chk("R11 exl kept", m_status, 32'h0000_0006);
    chk("R11 epc held", m_epc, 32'h2FFC);
    chk("R4 bd kept", m_cause, 32'h8000_0004);
    m_ret = 1; step();
    chk("R11 exl clr2", m_status, 32'h0000_0004);
  endtask

  task automatic t_debug();
    m_ll = 1; step();
    m_dbg = 1; m_exc = 1; m_code = 5'd7; m_addr = 32'h4000; m_dly = 1; step();
    chk("R6 pc", m_pc, 32'hBFC0_0200);
    chk("R6 depc", m_depc, 32'h3FFC);
    chk("R6 ctl", m_dctl, 32'hC000_0002);
    chk("R8 cause", m_cause, 32'h8000_0004);
    chk("R8 epc", m_epc, 32'h2FFC);
    chk("R8 status", m_status, 32'h0000_0004);
    chk("R9 ll dbg", 32'(m_llb), 0);
    m_dbg = 1; m_addr = 32'h5000; step();
    chk("R7 no vld", 32'(m_vld), 0);
    chk("R7 depc", m_depc, 32'h3FFC);
    chk("R7 ctl", m_dctl, 32'hC000_0002);
    chk("R7 pc", m_pc, 32'hBFC0_0200);
    m_ret = 1; step();
    chk("R11 dm clr", m_dctl, 32'h8000_0002);
    m_dbg = 1; m_addr = 32'h6000; step();
    chk("R6 dbd clr", m_dctl, 32'h4000_0002);
    chk("R6 depc2", m_depc, 32'h6000);
    chk("R10 vld dbg", 32'(m_vld), 1);
  endtask

  task automatic t_alt();
    a_exc = 1; a_code = 5'd4; a_addr = 32'h100; step();
    chk("R12 pc boot", a_pc, 32'hBFC0_0180);
    chk("R12 cause", a_cause, 32'h0000_0010);
    chk("R12 epc", a_epc, 32'h100);
    chk("R12 status", a_status, 32'h0040_0010);
    a_exc = 1; a_code = 5'd2; a_addr = 32'h200; a_dly = 1; step();
    chk("R12 epc back", a_epc, 32'h1FC);
    chk("R12 cause bd", a_cause, 32'h8000_0008);
    chk("R12 status2", a_status, 32'h0040_0000);
    a_bev = 1; step();
    a_exc = 1; a_code = 5'd6; a_addr = 32'h300; step();
    chk("R12 pc run", a_pc, 32'h8000_0180);
    chk("R12 epc always", a_epc, 32'h300);
    chk("R12 bd kept", a_cause, 32'h8000_0018);
    chk("R12 status3", a_status, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_exc();
    t_nested();
    t_ret_bev_delay();
    t_ret_race();
    t_debug();
    t_alt();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule